// File: doc/BRIEF.md
# Instruction Fetch Cache with Flush Sequencer

This block is a direct-mapped instruction cache placed between a processor's fetch port and a slower word-wide memory bus. A fetch that finds its word present and the cache switched on is answered in the same cycle. Any other fetch goes out to memory. A small configuration register switches the cache on and off. It also starts an invalidation sweep and picks how a miss refills a line: either the whole eight-word line as one locked transaction, or just the word that was asked for.

The tag, data and valid storage has no reset, so its contents survive a reset pulse. If software turns the cache on without first running an invalidation sweep, words left over from an earlier run can be served as hits. For this reason boot code should start a sweep, poll the busy bit until it drops, and only then set the enable bit. Addresses on both the fetch side and the memory side are word addresses.

Top module: `ifetch_cache`

## Requirements
- R1: After reset the configuration readback `cfg_rdata_o` is 3'b000, where bit 0 is enable, bit 1 is sweep busy and bit 2 is burst refill. No memory request is pending.
- R2: While bit 0 is clear, every fetch makes one non-burst memory read at the exact word address and returns that word. Nothing is allocated, so the same address misses again after the cache is turned on.
- R3: Writing `cfg_wdata_i` with bit 1 set while the block is idle sets readback bit 1. That bit stays high for exactly LINES cycles and then clears.
- R4: After an invalidation sweep, every previously cached word misses.
- R5: A fetch issued during a sweep gets no acknowledge until readback bit 1 has cleared.
- R6: Reset leaves the tags, valid bits and data unchanged. Turning the cache on without a sweep can return the old word as a hit with no memory traffic.
- R7: With bits 0 and 2 set, a miss issues one single-cycle request with `mem_burst_o` high at the line-aligned address (low three bits zero). It accepts eight beats in word order with `mem_lock_o` held high throughout, and afterwards all eight words of the line hit.
- R8: With bit 0 set and bit 2 clear, a miss issues one single-beat request at the exact word address with `mem_burst_o` and `mem_lock_o` low. Each word has its own valid bit, so only words already fetched hit, and words fetched earlier into the same line stay valid.
- R9: Placement is direct-mapped. The line index is address bits [6:3] and the word offset is bits [2:0]. A fetch with another tag at the same index evicts the line, while lines at other indices are unaffected.
- R10: A hit is acknowledged in the cycle the request is presented, with no memory request. Every acknowledged word equals the memory word at the requested address as it stood when that word was filled.
- R11: Bits 0 and 2 of a configuration write are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Write data: bit0 enable, bit1 start sweep, bit2 burst refill |
| cfg_rdata_o | output | 3 | Readback: bit0 enable, bit1 sweep busy, bit2 burst refill |
| fetch_req_i | input | 1 | Fetch request, held until acknowledged |
| fetch_addr_i | input | WADDR_W | Fetch word address |
| fetch_ack_o | output | 1 | Fetch acknowledge, one cycle |
| fetch_data_o | output | DATA_W | Fetched word, valid with acknowledge |
| mem_req_o | output | 1 | Single-cycle memory read command |
| mem_addr_o | output | WADDR_W | Memory word address (line base for bursts) |
| mem_burst_o | output | 1 | Command asks for a full eight-beat line |
| mem_lock_o | output | 1 | Bus held for an atomic burst |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | DATA_W | Read beat data |

## Verification
The checker assumes the fetch requester holds `fetch_req_i` and a stable address until the acknowledge. It assumes memory returns beats only after a command, in order, and exactly as many as the command asked for. It also assumes a sweep is started only when no fetch is outstanding; otherwise the acknowledge of an in-flight refill could coincide with the busy bit. The bench's memory model answers each command with one beat or eight beats after a fixed latency. All sweeps and configuration writes happen between fetches, and a fetch is issued during a sweep only after the sweep has started.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int unsigned CFG_W     = 3;
  localparam int unsigned CFG_EN    = 0;
  localparam int unsigned CFG_FLUSH = 1;
  localparam int unsigned CFG_BURST = 2;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT,
    FS_RESP
  } fill_state_e;
endpackage

// File: rtl/icache_cfg.sv
module icache_cfg
  import icache_pkg::*;
#(
  parameter int unsigned LINES = 16,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             walk_ok_i,
  output logic             en_o,
  output logic             burst_o,
  output logic             busy_o,
  output logic             clr_en_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  logic             en_q, burst_q, busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      burst_q <= 1'b0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (we_i) begin
        en_q    <= wdata_i[CFG_EN];
        burst_q <= wdata_i[CFG_BURST];
        if (wdata_i[CFG_FLUSH] && !busy_q) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
        end
      end
      // sweep advances one line per cycle once the fill engine is idle
      if (busy_q && walk_ok_i) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IDX_W'(LINES - 1)) busy_q <= 1'b0;
      end
    end
  end

  assign en_o      = en_q;
  assign burst_o   = burst_q;
  assign busy_o    = busy_q;
  assign clr_en_o  = busy_q && walk_ok_i;
  assign clr_idx_o = idx_q;
endmodule

// File: rtl/icache_store.sv
module icache_store #(
  parameter int unsigned WADDR_W    = 30,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned LINES      = 16,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS),
  localparam int unsigned TAG_W  = WADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_wvld_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              alloc_i,
  input  logic              alloc_keep_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i
);
  logic [LINES-1:0][TAG_W-1:0]                  tag_all;
  logic [LINES-1:0][LINE_WORDS-1:0]             vld_all;
  logic [LINES-1:0][LINE_WORDS-1:0][DATA_W-1:0] data_all;

  // no reset on storage: contents persist across reset by intent
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [TAG_W-1:0]                  tag_q;
    logic [LINE_WORDS-1:0]             vld_q;
    logic [LINE_WORDS-1:0][DATA_W-1:0] data_q;

    always_ff @(posedge clk_i) begin
      if (clr_en_i && clr_idx_i == IDX_W'(l)) begin
        vld_q <= '0;
      end else if (alloc_i && !alloc_keep_i && alloc_idx_i == IDX_W'(l)) begin
        tag_q <= alloc_tag_i;
        vld_q <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(l)) begin
        vld_q[wr_off_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(l)) data_q[wr_off_i] <= wr_data_i;
    end

    assign tag_all[l]  = tag_q;
    assign vld_all[l]  = vld_q;
    assign data_all[l] = data_q;
  end

  assign rd_tag_o  = tag_all[rd_idx_i];
  assign rd_wvld_o = vld_all[rd_idx_i][rd_off_i];
  assign rd_data_o = data_all[rd_idx_i][rd_off_i];
endmodule

// File: rtl/icache_fill.sv
module icache_fill
  import icache_pkg::*;
#(
  parameter int unsigned WADDR_W    = 30,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned LINES      = 16,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned OFF_W  = $clog2(LINE_WORDS),
  localparam int unsigned TAG_W  = WADDR_W - IDX_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_req_i,
  input  logic [WADDR_W-1:0] fetch_addr_i,
  output logic               fetch_ack_o,
  output logic [DATA_W-1:0]  fetch_data_o,
  input  logic               en_i,
  input  logic               burst_i,
  input  logic               busy_i,
  output logic               idle_o,
  output logic [IDX_W-1:0]   rd_idx_o,
  output logic [OFF_W-1:0]   rd_off_o,
  input  logic [TAG_W-1:0]   rd_tag_i,
  input  logic               rd_wvld_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               alloc_o,
  output logic               alloc_keep_o,
  output logic [IDX_W-1:0]   alloc_idx_o,
  output logic [TAG_W-1:0]   alloc_tag_o,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [OFF_W-1:0]   wr_off_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               mem_req_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic               mem_burst_o,
  output logic               mem_lock_o,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  fill_state_e        state_q, state_d;
  logic [WADDR_W-1:0] addr_q, rd_addr;
  logic               alloc_q, bmode_q;
  logic [OFF_W-1:0]   beat_q;
  logic [DATA_W-1:0]  rsp_q;
  logic               tag_eq, hit, start_miss, last_beat;

  logic [TAG_W-1:0] q_tag;
  logic [IDX_W-1:0] q_idx;
  logic [OFF_W-1:0] q_off;

  assign rd_addr  = (state_q == FS_IDLE) ? fetch_addr_i : addr_q;
  assign rd_idx_o = rd_addr[OFF_W +: IDX_W];
  assign rd_off_o = rd_addr[OFF_W-1:0];
  assign tag_eq   = (rd_tag_i == rd_addr[WADDR_W-1 -: TAG_W]);
  assign hit      = tag_eq && rd_wvld_i;

  assign q_tag = addr_q[WADDR_W-1 -: TAG_W];
  assign q_idx = addr_q[OFF_W +: IDX_W];
  assign q_off = addr_q[OFF_W-1:0];

  assign start_miss = (state_q == FS_IDLE) && fetch_req_i && !busy_i && !(en_i && hit);
  assign last_beat  = !bmode_q || (beat_q == OFF_W'(LINE_WORDS - 1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FS_IDLE: if (start_miss) state_d = FS_REQ;
      FS_REQ:  state_d = FS_WAIT;
      FS_WAIT: if (mem_rvalid_i && last_beat) state_d = FS_RESP;
      FS_RESP: state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      alloc_q <= 1'b0;
      bmode_q <= 1'b0;
      beat_q  <= '0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start_miss) begin
        addr_q  <= fetch_addr_i;
        alloc_q <= en_i;
        bmode_q <= en_i && burst_i;
      end
      if (state_q == FS_REQ) beat_q <= '0;
      if (state_q == FS_WAIT && mem_rvalid_i) begin
        beat_q <= beat_q + 1'b1;
        if (wr_off_o == q_off) rsp_q <= mem_rdata_i;
      end
    end
  end

  assign idle_o = (state_q == FS_IDLE);

  assign fetch_ack_o  = (state_q == FS_RESP) ||
                        ((state_q == FS_IDLE) && fetch_req_i && !busy_i && en_i && hit);
  assign fetch_data_o = (state_q == FS_RESP) ? rsp_q : rd_data_i;

  // single-word refill into a line that already holds this tag keeps its other words
  assign alloc_o      = (state_q == FS_REQ) && alloc_q;
  assign alloc_keep_o = !bmode_q && tag_eq;
  assign alloc_idx_o  = q_idx;
  assign alloc_tag_o  = q_tag;

  assign wr_en_o   = (state_q == FS_WAIT) && mem_rvalid_i && alloc_q;
  assign wr_idx_o  = q_idx;
  assign wr_off_o  = bmode_q ? beat_q : q_off;
  assign wr_data_o = mem_rdata_i;

  assign mem_req_o   = (state_q == FS_REQ);
  assign mem_addr_o  = bmode_q ? {addr_q[WADDR_W-1:OFF_W], {OFF_W{1'b0}}} : addr_q;
  assign mem_burst_o = bmode_q;
  assign mem_lock_o  = bmode_q && ((state_q == FS_REQ) || (state_q == FS_WAIT));
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import icache_pkg::*;
#(
  parameter int unsigned WADDR_W    = 30,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned LINES      = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic [CFG_W-1:0]   cfg_rdata_o,
  input  logic               fetch_req_i,
  input  logic [WADDR_W-1:0] fetch_addr_i,
  output logic               fetch_ack_o,
  output logic [DATA_W-1:0]  fetch_data_o,
  output logic               mem_req_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic               mem_burst_o,
  output logic               mem_lock_o,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned OFF_W = $clog2(LINE_WORDS);
  localparam int unsigned TAG_W = WADDR_W - IDX_W - OFF_W;

  logic              en, burst, busy, idle, clr_en;
  logic [IDX_W-1:0]  clr_idx, rd_idx, alloc_idx, wr_idx;
  logic [OFF_W-1:0]  rd_off, wr_off;
  logic [TAG_W-1:0]  rd_tag, alloc_tag;
  logic              rd_wvld, alloc, alloc_keep, wr_en;
  logic [DATA_W-1:0] rd_data, wr_data;

  icache_cfg #(.LINES(LINES)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .walk_ok_i (idle),
    .en_o      (en),
    .burst_o   (burst),
    .busy_o    (busy),
    .clr_en_o  (clr_en),
    .clr_idx_o (clr_idx)
  );

  icache_store #(
    .WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
  ) i_store (
    .clk_i        (clk_i),
    .rd_idx_i     (rd_idx),
    .rd_off_i     (rd_off),
    .rd_tag_o     (rd_tag),
    .rd_wvld_o    (rd_wvld),
    .rd_data_o    (rd_data),
    .alloc_i      (alloc),
    .alloc_keep_i (alloc_keep),
    .alloc_idx_i  (alloc_idx),
    .alloc_tag_i  (alloc_tag),
    .wr_en_i      (wr_en),
    .wr_idx_i     (wr_idx),
    .wr_off_i     (wr_off),
    .wr_data_i    (wr_data),
    .clr_en_i     (clr_en),
    .clr_idx_i    (clr_idx)
  );

  icache_fill #(
    .WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
  ) i_fill (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_req_i  (fetch_req_i),
    .fetch_addr_i (fetch_addr_i),
    .fetch_ack_o  (fetch_ack_o),
    .fetch_data_o (fetch_data_o),
    .en_i         (en),
    .burst_i      (burst),
    .busy_i       (busy),
    .idle_o       (idle),
    .rd_idx_o     (rd_idx),
    .rd_off_o     (rd_off),
    .rd_tag_i     (rd_tag),
    .rd_wvld_i    (rd_wvld),
    .rd_data_i    (rd_data),
    .alloc_o      (alloc),
    .alloc_keep_o (alloc_keep),
    .alloc_idx_o  (alloc_idx),
    .alloc_tag_o  (alloc_tag),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_off_o     (wr_off),
    .wr_data_o    (wr_data),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_burst_o  (mem_burst_o),
    .mem_lock_o   (mem_lock_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i)
  );

  always_comb begin
    cfg_rdata_o            = '0;
    cfg_rdata_o[CFG_EN]    = en;
    cfg_rdata_o[CFG_FLUSH] = busy;
    cfg_rdata_o[CFG_BURST] = burst;
  end
endmodule

// File: rtl/ifetch_cache_chk.sv
module ifetch_cache_chk #(
  parameter int unsigned LINES      = 16,
  parameter int unsigned LINE_WORDS = 8,
  localparam int unsigned OFF_W = $clog2(LINE_WORDS),
  localparam int unsigned CNT_W = $clog2(LINES) + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cfg_rdata_o,
  input logic             fetch_req_i,
  input logic             fetch_ack_o,
  input logic             mem_req_o,
  input logic [OFF_W-1:0] mem_off,
  input logic             mem_burst_o,
  input logic             mem_lock_o,
  input logic             mem_rvalid_i
);
  logic             busy;
  logic [CNT_W-1:0] busy_cnt_q;

  assign busy = cfg_rdata_o[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    busy_cnt_q <= '0;
    else if (!busy)                 busy_cnt_q <= '0;
    else if (busy_cnt_q != '1)      busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  assert_flush_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> busy_cnt_q >= CNT_W'(LINES));

  assert_no_ack_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ack_o |-> !busy);

  assert_burst_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_burst_o) |-> ($past(cfg_rdata_o[0]) && $past(cfg_rdata_o[2])));

  assert_burst_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_burst_o) |-> (mem_off == '0));

  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_lock_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_lock_o) |-> $past(mem_rvalid_i));

  assert_ack_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ack_o |-> fetch_req_i);
endmodule

bind ifetch_cache ifetch_cache_chk #(.LINES(LINES), .LINE_WORDS(LINE_WORDS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_rdata_o  (cfg_rdata_o),
  .fetch_req_i  (fetch_req_i),
  .fetch_ack_o  (fetch_ack_o),
  .mem_req_o    (mem_req_o),
  .mem_off      (mem_addr_o[$clog2(LINE_WORDS)-1:0]),
  .mem_burst_o  (mem_burst_o),
  .mem_lock_o   (mem_lock_o),
  .mem_rvalid_i (mem_rvalid_i)
);

// File: tb/test_ifetch_cache.sv
`timescale 1ns/1ps
module test_ifetch_cache;
  localparam int LINES = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_wdata_i = '0;
  logic [2:0]  cfg_rdata_o;
  logic        fetch_req_i = 1'b0;
  logic [29:0] fetch_addr_i = '0;
  logic        fetch_ack_o;
  logic [31:0] fetch_data_o;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic        mem_burst_o;
  logic        mem_lock_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;

  int          n_tests = 0;
  int          n_fail  = 0;
  int          txn_cnt = 0;
  int          lock_err = 0;
  logic [29:0] last_addr = '0;
  logic        last_burst = 1'b0;
  logic [7:0]  gen_q = 8'h11;
  logic        ack_busy = 1'b0;
  bit          done = 1'b0;

  initial forever #2.5 clk_i = ~clk_i;

  ifetch_cache i_ifetch_cache (.*);

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return {gen_q, a[23:0]};
  endfunction

  function automatic logic [29:0] mk(input logic [22:0] t, input logic [3:0] i, input logic [2:0] o);
    return {t, i, o};
  endfunction

  // memory model: fixed latency, one or eight beats
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && mem_req_o) begin
        int nb;
        txn_cnt++;
        last_addr  = mem_addr_o;
        last_burst = mem_burst_o;
        nb = mem_burst_o ? 8 : 1;
        repeat (2) @(negedge clk_i);
        for (int b = 0; b < nb; b++) begin
          if (mem_lock_o !== last_burst) lock_err++;
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_word(last_burst ? {last_addr[29:3], 3'(b)} : last_addr);
          @(negedge clk_i);
        end
        mem_rvalid_i = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic cfg_write(input bit en, input bit fl, input bit bu);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = {bu, fl, en};
    @(negedge clk_i);
    cfg_we_i    = 1'b0;
  endtask

  task automatic wait_sweep(output int n);
    n = 0;
    while (cfg_rdata_o[1] && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic fetch(input logic [29:0] a, output logic [31:0] d, output int cyc);
    @(negedge clk_i);
    fetch_addr_i = a;
    fetch_req_i  = 1'b1;
    cyc = 0;
    forever begin
      #1;
      if (fetch_ack_o) break;
      @(negedge clk_i);
      cyc++;
      if (cyc > 500) break;
    end
    d = fetch_data_o;
    ack_busy = cfg_rdata_o[1];
    @(negedge clk_i);
    fetch_req_i = 1'b0;
  endtask

  // fetch and check data plus hit/miss behaviour
  task automatic fetch_chk(input string req, input logic [29:0] a, input bit exp_hit,
                           input logic [31:0] exp_d);
    logic [31:0] d;
    int cyc, t0;
    t0 = txn_cnt;
    fetch(a, d, cyc);
    check(d === exp_d, req, d, exp_d);
    if (exp_hit) check(cyc == 0 && txn_cnt == t0, {req, " hit"}, 32'(txn_cnt - t0), 0);
    else         check(txn_cnt == t0 + 1, {req, " miss"}, 32'(txn_cnt - t0), 1);
  endtask

  task automatic t_reset_state();
    check(cfg_rdata_o === 3'b000, "R1 readback", 32'(cfg_rdata_o), 0);
    check(mem_req_o === 1'b0, "R1 mem idle", 32'(mem_req_o), 0);
  endtask

  task automatic t_flush_time();
    int n;
    cfg_write(1'b0, 1'b1, 1'b0);
    wait_sweep(n);
    check(n == LINES, "R3 busy cycles", 32'(n), LINES);
  endtask

  task automatic t_disabled();
    logic [29:0] a = mk(23'h12, 4'h2, 3'h5);
    fetch_chk("R2 disabled", a, 1'b0, mem_word(a));
    check(last_burst == 1'b0 && last_addr == a, "R2 single", 32'(last_addr), 32'(a));
    fetch_chk("R2 disabled again", a, 1'b0, mem_word(a));
    cfg_write(1'b1, 1'b0, 1'b1);
    fetch_chk("R2 no allocate", a, 1'b0, mem_word(a));
  endtask

  task automatic t_cfg_readback();
    cfg_write(1'b1, 1'b0, 1'b1);
    check(cfg_rdata_o === 3'b101, "R11 en+burst", 32'(cfg_rdata_o), 32'h5);
    cfg_write(1'b1, 1'b0, 1'b0);
    check(cfg_rdata_o === 3'b001, "R11 en only", 32'(cfg_rdata_o), 32'h1);
  endtask

  task automatic t_burst();
    int n;
    logic [29:0] a = mk(23'h345, 4'h7, 3'h5);
    cfg_write(1'b1, 1'b1, 1'b1);
    wait_sweep(n);
    lock_err = 0;
    fetch_chk("R7 burst miss", a, 1'b0, mem_word(a));
    check(last_burst == 1'b1, "R7 burst flag", 32'(last_burst), 1);
    check(last_addr == {a[29:3], 3'b000}, "R7 aligned addr", 32'(last_addr), 32'({a[29:3], 3'b000}));
    check(lock_err == 0, "R7 lock held", 32'(lock_err), 0);
    for (int o = 0; o < 8; o++) begin
      logic [29:0] b = mk(23'h345, 4'h7, 3'(o));
      fetch_chk("R10 line hit", b, 1'b1, mem_word(b));
    end
  endtask

  task automatic t_flush_inval();
    int n;
    logic [29:0] a = mk(23'h345, 4'h7, 3'h2);
    cfg_write(1'b1, 1'b1, 1'b1);
    wait_sweep(n);
    fetch_chk("R4 after sweep", a, 1'b0, mem_word(a));
  endtask

  task automatic t_single();
    int n;
    logic [29:0] a2 = mk(23'h0AB, 4'h9, 3'h2);
    logic [29:0] a6 = mk(23'h0AB, 4'h9, 3'h6);
    logic [29:0] a3 = mk(23'h0AB, 4'h9, 3'h3);
    cfg_write(1'b1, 1'b1, 1'b0);
    wait_sweep(n);
    lock_err = 0;
    fetch_chk("R8 word miss", a2, 1'b0, mem_word(a2));
    check(last_burst == 1'b0 && last_addr == a2, "R8 exact addr", 32'(last_addr), 32'(a2));
    check(lock_err == 0, "R8 no lock", 32'(lock_err), 0);
    fetch_chk("R8 word hit", a2, 1'b1, mem_word(a2));
    fetch_chk("R8 other word miss", a6, 1'b0, mem_word(a6));
    fetch_chk("R8 first word kept", a2, 1'b1, mem_word(a2));
    fetch_chk("R8 second word hit", a6, 1'b1, mem_word(a6));
    fetch_chk("R8 unfetched word", a3, 1'b0, mem_word(a3));
  endtask

  task automatic t_conflict();
    int n;
    logic [29:0] a = mk(23'h001, 4'h3, 3'h1);
    logic [29:0] b = mk(23'h002, 4'h3, 3'h1);
    logic [29:0] c = mk(23'h002, 4'h4, 3'h0);
    cfg_write(1'b1, 1'b1, 1'b1);
    wait_sweep(n);
    fetch_chk("R9 fill a", a, 1'b0, mem_word(a));
    fetch_chk("R9 same index other tag", b, 1'b0, mem_word(b));
    fetch_chk("R9 a evicted", a, 1'b0, mem_word(a));
    fetch_chk("R9 other index", c, 1'b0, mem_word(c));
    fetch_chk("R9 c kept", c, 1'b1, mem_word(c));
  endtask

  task automatic t_stall();
    logic [31:0] d;
    int cyc, t0;
    logic [29:0] c = mk(23'h002, 4'h4, 3'h0);
    t0 = txn_cnt;
    cfg_write(1'b1, 1'b1, 1'b1);
    fetch(c, d, cyc);
    check(cyc >= LINES - 2, "R5 stalled", 32'(cyc), LINES - 2);
    check(ack_busy == 1'b0, "R5 ack after sweep", 32'(ack_busy), 0);
    check(d === mem_word(c) && txn_cnt == t0 + 1, "R5 refetched", d, mem_word(c));
  endtask

  task automatic t_stale();
    int n;
    logic [29:0] a = mk(23'h7F0, 4'hC, 3'h4);
    logic [31:0] old_d;
    cfg_write(1'b1, 1'b1, 1'b1);
    wait_sweep(n);
    fetch_chk("R6 prime", a, 1'b0, mem_word(a));
    old_d = mem_word(a);
    do_reset();
    check(cfg_rdata_o === 3'b000, "R1 readback after reset", 32'(cfg_rdata_o), 0);
    gen_q = 8'h22;
    cfg_write(1'b1, 1'b0, 1'b1);
    fetch_chk("R6 stale hit", a, 1'b1, old_d);
    cfg_write(1'b1, 1'b1, 1'b1);
    wait_sweep(n);
    fetch_chk("R6 fresh after sweep", a, 1'b0, mem_word(a));
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_flush_time();
    t_disabled();
    t_cfg_readback();
    t_burst();
    t_flush_inval();
    t_single();
    t_conflict();
    t_stall();
    t_stale();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule